// File: doc/BRIEF.md
# ISA Bus Slave Address Decoder

This block watches the cycles a host drives on an ISA bus and decides which of them are meant for the peripheral behind it. It offers two decode spaces side by side. The I/O space is always on: a 16-byte window of eight 16-bit ports placed at a programmable base. The memory space is a 4-Kbyte window at a second programmable base, and it answers only while the memory-mode enable input is set. Each space has its own pair of active-low strobes and its own qualification rules. I/O cycles need the address-enable line low; memory cycles do not look at it.

The strobes are asynchronous to the local clock, so each one passes through a synchroniser. On the falling edge of a synchronised strobe the block issues a one-cycle read-enable or write-enable pulse. It also captures the port index or the byte offset and holds it. While the strobe stays low and the address still hits, a level select output stays high. If both strobes of a space are low together, that space treats the cycle as invalid and ignores it. Bus drivers and data steering sit outside this block.

Top module: `isa_slave_decode`

## Requirements
- R1: While reset is asserted, and after it, until a qualified strobe falls, every pulse and select output is 0.
- R2: An I/O read hits when `aen` is 0, `ior_n` falls while `iow_n` is high, and `sa[15:4]` equals `io_base[15:4]`. The block then raises `io_rd` for exactly one cycle. The pulse is visible after the third rising clock edge following the fall, and `io_port` shows `sa[3:1]` in the same cycle.
- R3: An I/O write has the same qualification and timing as R2, with `iow_n` falling while `ior_n` is high. It produces an `io_wr` pulse and `io_port` = `sa[3:1]`.
- R4: While `aen` is 1, no I/O strobe produces `io_rd`, `io_wr` or `io_sel`.
- R5: An I/O access whose `sa[15:4]` differs from `io_base[15:4]` gets no response. Bits `io_base[3:0]` have no effect on the decode.
- R6: A memory access hits when `mem_mode` is 1 and `sa[15:12]` equals `mem_base[15:12]`. A falling `memr_n` or `memw_n`, with the other strobe high, gives a one-cycle `mem_rd` or `mem_wr` pulse with R2 timing, and `mem_offset` = `sa[11:0]`. An address outside the window gets no response.
- R7: While `mem_mode` is 0, memory strobes give no `mem_rd`, `mem_wr` or `mem_sel`. I/O decoding works regardless of `mem_mode`.
- R8: If both strobes of one space are low together, that space gives no pulse and no select.
- R9: A strobe held low for many cycles gives exactly one pulse. Another pulse needs the strobe to go high and fall again.
- R10: `io_sel` (or `mem_sel`) rises in the same cycle as its pulse. It stays high while the strobe is held low and falls three rising edges after the strobe returns high. While a select stays high, the captured index does not change.
- R11: Memory decoding ignores `aen`. A hit with `aen` = 1 still produces its pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sa | input | 16 | System address bus |
| aen | input | 1 | Address enable; high during DMA, blocks I/O decode |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| io_base | input | 16 | I/O window base; bits 3:0 ignored |
| mem_base | input | 16 | Memory window base; bits 11:0 ignored |
| mem_mode | input | 1 | Enables the memory window |
| io_sel | output | 1 | I/O window selected while strobe held |
| io_rd | output | 1 | One-cycle I/O read enable |
| io_wr | output | 1 | One-cycle I/O write enable |
| io_port | output | 3 | Port index of the current I/O access |
| mem_sel | output | 1 | Memory window selected while strobe held |
| mem_rd | output | 1 | One-cycle memory read enable |
| mem_wr | output | 1 | One-cycle memory write enable |
| mem_offset | output | 12 | Byte offset of the current memory access |

## Verification
The only hidden state is the synchroniser chain and the remembered previous strobe level. If that state is corrupted, the ports show a missing, doubled or early pulse. A stuck previous-level bit shows either a pulse on every cycle of a held strobe or none at all, and the bench sees this within four cycles of the strobe falling. A fault in the captured index shows as a wrong `io_port` or `mem_offset` in the same cycle as the pulse. A fault in the select path shows when the select drops out early or lingers past the third edge after release.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;
    localparam int ADDR_W    = 16;
    localparam int IO_PORTS  = 8;
    localparam int PORT_W    = $clog2(IO_PORTS);
    localparam int IO_LOW    = PORT_W + 1;      // byte bits covered by the I/O window
    localparam int MEM_OFF_W = 12;              // 4 Kbyte window
    localparam int N_STRB    = 4;

    // Index of each strobe in the synchronised active-high vector
    localparam int S_IOR  = 0;
    localparam int S_IOW  = 1;
    localparam int S_MEMR = 2;
    localparam int S_MEMW = 3;

    typedef struct packed {
        logic [N_STRB-1:0]    strb_prev;
        logic                 io_sel;
        logic                 io_rd;
        logic                 io_wr;
        logic [PORT_W-1:0]    io_port;
        logic                 mem_sel;
        logic                 mem_rd;
        logic                 mem_wr;
        logic [MEM_OFF_W-1:0] mem_off;
    } dec_state_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] strb_n,
    output logic [WIDTH-1:0] active
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], ~strb_n[g]};
        end
        assign active[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/window_match.sv
module window_match #(
    parameter int ADDR_W   = 16,
    parameter int LOW_BITS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output logic              hit
);
    assign hit = (addr[ADDR_W-1:LOW_BITS] == base[ADDR_W-1:LOW_BITS]);
endmodule

// File: rtl/isa_slave_decode.sv
module isa_slave_decode
    import isa_dec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    sa,
    input  logic                 aen,
    input  logic                 ior_n,
    input  logic                 iow_n,
    input  logic                 memr_n,
    input  logic                 memw_n,
    input  logic [ADDR_W-1:0]    io_base,
    input  logic [ADDR_W-1:0]    mem_base,
    input  logic                 mem_mode,
    output logic                 io_sel,
    output logic                 io_rd,
    output logic                 io_wr,
    output logic [PORT_W-1:0]    io_port,
    output logic                 mem_sel,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [MEM_OFF_W-1:0] mem_offset
);
    logic [N_STRB-1:0] act;
    logic [N_STRB-1:0] fall;
    logic              io_win, mem_win, io_hit, mem_hit;
    logic              rd_io_go, wr_io_go, rd_mem_go, wr_mem_go;
    dec_state_t        st_d, st_q;

    strobe_sync #(.WIDTH(N_STRB), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_n ({memw_n, memr_n, iow_n, ior_n}),
        .active (act)
    );

    window_match #(.ADDR_W(ADDR_W), .LOW_BITS(IO_LOW)) u_io_win (
        .addr (sa),
        .base (io_base),
        .hit  (io_win)
    );

    window_match #(.ADDR_W(ADDR_W), .LOW_BITS(MEM_OFF_W)) u_mem_win (
        .addr (sa),
        .base (mem_base),
        .hit  (mem_win)
    );

    always_comb begin
        io_hit  = io_win && !aen;
        mem_hit = mem_win && mem_mode;
        fall    = act & ~st_q.strb_prev;

        rd_io_go  = fall[S_IOR]  && !act[S_IOW]  && io_hit;
        wr_io_go  = fall[S_IOW]  && !act[S_IOR]  && io_hit;
        rd_mem_go = fall[S_MEMR] && !act[S_MEMW] && mem_hit;
        wr_mem_go = fall[S_MEMW] && !act[S_MEMR] && mem_hit;

        st_d           = st_q;
        st_d.strb_prev = act;
        st_d.io_rd     = rd_io_go;
        st_d.io_wr     = wr_io_go;
        st_d.mem_rd    = rd_mem_go;
        st_d.mem_wr    = wr_mem_go;
        st_d.io_sel    = (act[S_IOR] ^ act[S_IOW]) && io_hit;
        st_d.mem_sel   = (act[S_MEMR] ^ act[S_MEMW]) && mem_hit;

        if (rd_io_go || wr_io_go)
            st_d.io_port = sa[IO_LOW-1:1];
        if (rd_mem_go || wr_mem_go)
            st_d.mem_off = sa[MEM_OFF_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign io_sel     = st_q.io_sel;
    assign io_rd      = st_q.io_rd;
    assign io_wr      = st_q.io_wr;
    assign io_port    = st_q.io_port;
    assign mem_sel    = st_q.mem_sel;
    assign mem_rd     = st_q.mem_rd;
    assign mem_wr     = st_q.mem_wr;
    assign mem_offset = st_q.mem_off;
endmodule

// File: rtl/isa_slave_decode_chk.sv
module isa_slave_decode_chk
    import isa_dec_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 aen,
    input logic                 mem_mode,
    input logic                 io_sel,
    input logic                 io_rd,
    input logic                 io_wr,
    input logic [PORT_W-1:0]    io_port,
    input logic                 mem_sel,
    input logic                 mem_rd,
    input logic                 mem_wr,
    input logic [MEM_OFF_W-1:0] mem_offset
);
    a_r9_io_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> !io_rd);
    a_r9_mem_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);
    a_r10_io_pulse_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> io_sel);
    a_r10_mem_pulse_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> mem_sel);
    a_r10_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && $past(io_sel)) |-> $stable(io_port));
    a_r10_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel && $past(mem_sel)) |-> $stable(mem_offset));
    a_r8_io_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));
    a_r4_aen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> $past(!aen));
    a_r7_mem_gated: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> $past(mem_mode));
endmodule

bind isa_slave_decode isa_slave_decode_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .aen        (aen),
    .mem_mode   (mem_mode),
    .io_sel     (io_sel),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_port    (io_port),
    .mem_sel    (mem_sel),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_offset (mem_offset)
);

// File: tb/sim_isa_slave_decode.sv
module sim_isa_slave_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sa = '0;
    logic        aen = 1'b0;
    logic        ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1;
    logic [15:0] io_base = 16'h0300;
    logic [15:0] mem_base = 16'hD000;
    logic        mem_mode = 1'b0;
    logic        io_sel, io_rd, io_wr, mem_sel, mem_rd, mem_wr;
    logic [2:0]  io_port;
    logic [11:0] mem_offset;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    isa_slave_decode u0 (
        .clk(clk), .rst_n(rst_n), .sa(sa), .aen(aen),
        .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
        .io_base(io_base), .mem_base(mem_base), .mem_mode(mem_mode),
        .io_sel(io_sel), .io_rd(io_rd), .io_wr(io_wr), .io_port(io_port),
        .mem_sel(mem_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_offset(mem_offset)
    );

    // {aen, mem_mode, {ior_n,iow_n,memr_n,memw_n}, sa, {io_rd,io_wr,mem_rd,mem_wr}, index}
    localparam int NV = 14;
    localparam logic [37:0] VECS [NV] = '{
        {1'b0, 1'b0, 4'b0111, 16'h0306, 4'b1000, 12'h003},  // R2
        {1'b0, 1'b0, 4'b1011, 16'h030E, 4'b0100, 12'h007},  // R3
        {1'b0, 1'b0, 4'b0111, 16'h0300, 4'b1000, 12'h000},  // R2
        {1'b1, 1'b0, 4'b0111, 16'h0306, 4'b0000, 12'h000},  // R4
        {1'b0, 1'b0, 4'b0111, 16'h0310, 4'b0000, 12'h000},  // R5
        {1'b0, 1'b0, 4'b1011, 16'h1306, 4'b0000, 12'h000},  // R5
        {1'b0, 1'b1, 4'b1101, 16'hD0A4, 4'b0010, 12'h0A4},  // R6
        {1'b0, 1'b1, 4'b1110, 16'hDFFE, 4'b0001, 12'hFFE},  // R6
        {1'b0, 1'b0, 4'b1101, 16'hD0A4, 4'b0000, 12'h000},  // R7
        {1'b0, 1'b1, 4'b1101, 16'hE000, 4'b0000, 12'h000},  // R6
        {1'b0, 1'b0, 4'b0011, 16'h0304, 4'b0000, 12'h000},  // R8
        {1'b0, 1'b1, 4'b1100, 16'hD010, 4'b0000, 12'h000},  // R8
        {1'b1, 1'b1, 4'b1101, 16'hD002, 4'b0010, 12'h002},  // R11
        {1'b0, 1'b0, 4'b0111, 16'h0302, 4'b1000, 12'h001}   // R7: I/O works without memory mode
    };
    string vreq [NV] = '{"R2", "R3", "R2", "R4", "R5", "R5", "R6", "R6",
                         "R7", "R6", "R8", "R8", "R11", "R7"};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        ior_n = 1'b1; iow_n = 1'b1; memr_n = 1'b1; memw_n = 1'b1;
    endtask

    task automatic run_vec(input int i);
        logic [37:0] v;
        logic [3:0]  e;
        v = VECS[i];
        e = v[15:12];
        @(negedge clk);
        aen = v[37]; mem_mode = v[36]; sa = v[31:16];
        {ior_n, iow_n, memr_n, memw_n} = v[35:32];
        repeat (3) @(negedge clk);
        chk({io_rd, io_wr, mem_rd, mem_wr} == e, vreq[i], "pulses",
            {io_rd, io_wr, mem_rd, mem_wr}, e);
        chk({io_sel, mem_sel} == {e[3] | e[2], e[1] | e[0]}, vreq[i], "selects",
            {io_sel, mem_sel}, {e[3] | e[2], e[1] | e[0]});
        if (e[3] | e[2])
            chk(io_port == v[2:0], vreq[i], "io_port", io_port, v[2:0]);
        if (e[1] | e[0])
            chk(mem_offset == v[11:0], vreq[i], "mem_offset", mem_offset, v[11:0]);
        @(negedge clk);
        chk({io_rd, io_wr, mem_rd, mem_wr} == 4'b0, "R9", "pulse width",
            {io_rd, io_wr, mem_rd, mem_wr}, 0);
        idle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt;
        // R1: outputs quiet in and just after reset
        repeat (3) @(negedge clk);
        chk({io_sel, io_rd, io_wr, mem_sel, mem_rd, mem_wr} == 6'b0, "R1", "reset outputs",
            {io_sel, io_rd, io_wr, mem_sel, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({io_sel, io_rd, io_wr, mem_sel, mem_rd, mem_wr} == 6'b0, "R1", "idle outputs",
            {io_sel, io_rd, io_wr, mem_sel, mem_rd, mem_wr}, 0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R9: long strobe gives one pulse, re-assertion gives another
        aen = 1'b0; sa = 16'h0308;
        for (int k = 0; k < 2; k++) begin
            cnt = 0;
            ior_n = 1'b0;
            repeat (14) begin
                @(negedge clk);
                if (io_rd) cnt++;
            end
            chk(cnt == 1, "R9", "pulses per held strobe", cnt, 1);
            idle();
            repeat (4) @(negedge clk);
        end

        // R10: select timing around release
        sa = 16'h030C; iow_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(io_sel && io_wr, "R10", "sel with pulse", {io_sel, io_wr}, 3);
        repeat (5) @(negedge clk);
        chk(io_sel && io_port == 3'd6, "R10", "sel held / port", {io_sel, io_port}, {1'b1, 3'd6});
        iow_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(io_sel, "R10", "sel before drop", io_sel, 1);
        @(negedge clk);
        chk(!io_sel, "R10", "sel after drop", io_sel, 0);
        repeat (3) @(negedge clk);

        // R5: low base bits have no effect
        io_base = 16'h030F; sa = 16'h030A; ior_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(io_rd && io_port == 3'd5, "R5", "low base bits ignored", {io_rd, io_port}, {1'b1, 3'd5});
        idle();
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule